// File: doc/BRIEF.md
# Searchable Pipeline FIFO

This block is a queue that sits between two stages of an instruction pipeline. The producer stage pushes decoded instruction templates into it, and the consumer stage reads and retires them in order. Each template carries a kind tag, a destination register name and two operand values. The block has a synchronous clear that the consumer uses to flush wrong-path work after a taken branch.

The block also has a combinational lookup port. The producer presents a register name on it and learns whether any template still queued will write that register. The producer uses this to decide whether to stall.

The ordering inside one clock cycle is fixed. Reading the head and dequeuing come first. Searching and enqueuing come after them, so a slot freed by a dequeue can take a new template in the same cycle, and the lookup no longer sees the template that is leaving. A clear overrides every other request in that cycle. The depth is a parameter and may be any value of at least 1.

Top module: `search_pipe_fifo`

## Requirements
- R1: `deq_rdy` is high exactly when at least one template is stored. While it is high, the head outputs show the oldest stored template.
- R2: Templates leave the queue in the order in which they were accepted.
- R3: `enq_rdy` is high whenever fewer than DEPTH templates are stored. A push while `enq_rdy` is low is dropped, and the occupancy never exceeds DEPTH.
- R4: When the queue is full and `deq_en` is asserted, `enq_rdy` is high. A push in that cycle is accepted together with the pop.
- R5: A cycle with `clr` high leaves the queue empty in the next cycle. Any push or pop requested in that same cycle is discarded.
- R6: In a cycle with a pop, the head outputs still show the template being removed.
- R7: `srch_hit` is high exactly when a stored template of kind add (code 0) or load (code 2) has a destination equal to `srch_reg`. Kinds branch (code 1) and store (code 3) never match.
- R8: In a cycle where a pop takes effect, `srch_hit` ignores the head template. A template pushed in the same cycle is never seen by the lookup in that cycle.
- R9: `srch_hit` is low whenever the queue is empty.
- R10: After reset the queue is empty: `deq_rdy` is low, `enq_rdy` is high and `srch_hit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Push request |
| enq_kind | input | 2 | Kind of the pushed template (0 add, 1 branch, 2 load, 3 store) |
| enq_dst | input | 5 | Destination register of the pushed template |
| enq_opa | input | 32 | First operand value of the pushed template |
| enq_opb | input | 32 | Second operand value of the pushed template |
| enq_rdy | output | 1 | A push is accepted this cycle |
| deq_en | input | 1 | Pop request |
| deq_rdy | output | 1 | Queue not empty |
| head_kind | output | 2 | Kind of the oldest template |
| head_dst | output | 5 | Destination of the oldest template |
| head_opa | output | 32 | First operand of the oldest template |
| head_opb | output | 32 | Second operand of the oldest template |
| clr | input | 1 | Flush all stored templates |
| srch_reg | input | 5 | Register name to look up |
| srch_hit | output | 1 | A pending template writes `srch_reg` |

## Verification
The bench drives the full-and-pop-with-push case. A design that gates `enq_rdy` only on occupancy would drop that push and reorder the later contents. It looks up the destination of the head template in the same cycle the head is popped; a design that forgets to exclude the head would report a false hazard and stall the producer. It raises clear together with a push and a pop; a design that lets the push through would leave a stale template after the flush. It also pushes branch and store templates whose destination field equals the key, to catch a match rule that ignores the kind tag.

// File: rtl/sfq_pkg.sv
package sfq_pkg;

    localparam int REG_W = 5;
    localparam int VAL_W = 32;

    typedef enum logic [1:0] {
        TK_ADD    = 2'd0,
        TK_BRANCH = 2'd1,
        TK_LOAD   = 2'd2,
        TK_STORE  = 2'd3
    } tmpl_kind_e;

    typedef struct packed {
        tmpl_kind_e         kind;
        logic [REG_W-1:0]   dst;
        logic [VAL_W-1:0]   opa;
        logic [VAL_W-1:0]   opb;
    } tmpl_t;

    localparam int TMPL_W = $bits(tmpl_t);

    // Only templates that retire into the register file count as writers.
    function automatic logic writes_reg(tmpl_t t, logic [REG_W-1:0] r);
        case (t.kind)
            TK_ADD, TK_LOAD: return t.dst == r;
            default:         return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sfq_ptr_ctrl.sv
module sfq_ptr_ctrl #(
    parameter int DEPTH = 4,
    parameter int PW    = 2,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          enq_valid,
    input  logic          deq_en,
    output logic          enq_rdy,
    output logic          deq_rdy,
    output logic          enq_fire,
    output logic          deq_fire,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] wr_ptr,
    output logic [CW-1:0] occ
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

    function automatic logic [PW-1:0] step_ptr(logic [PW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    logic pop_req;

    assign deq_rdy  = (occ != '0);
    assign pop_req  = deq_en && deq_rdy;
    // A pop in the same cycle frees a slot before the push lands.
    assign enq_rdy  = (occ != FULL_CNT) || pop_req;
    assign deq_fire = pop_req && !clr;
    assign enq_fire = enq_valid && enq_rdy && !clr;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
        end else begin
            if (enq_fire) wr_ptr <= step_ptr(wr_ptr);
            if (deq_fire) rd_ptr <= step_ptr(rd_ptr);
            case ({enq_fire, deq_fire})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end
endmodule

// File: rtl/sfq_store.sv
module sfq_store
    import sfq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PW    = 2
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  tmpl_t         wr_data,
    input  logic [PW-1:0] rd_ptr,
    output tmpl_t         head,
    output tmpl_t         slots [DEPTH]
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_ptr == PW'(g))) slots[g] <= wr_data;
        end
    end

    always_comb begin
        head = slots[0];
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_ptr == PW'(i)) head = slots[i];
        end
    end
endmodule

// File: rtl/sfq_search.sv
module sfq_search
    import sfq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PW    = 2,
    parameter int CW    = 3
) (
    input  tmpl_t            slots [DEPTH],
    input  logic [PW-1:0]    rd_ptr,
    input  logic [CW-1:0]    occ,
    input  logic             skip_head,
    input  logic [REG_W-1:0] key,
    output logic             hit
);
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [PW:0] age;
        logic        live;

        // Age of slot g counted from the head, modulo DEPTH.
        always_comb begin
            if (PW'(g) >= rd_ptr) age = (PW+1)'(g) - {1'b0, rd_ptr};
            else                  age = (PW+1)'(g + DEPTH) - {1'b0, rd_ptr};
        end

        assign live     = (32'(age) < 32'(occ)) && !(skip_head && (age == '0));
        assign match[g] = live && writes_reg(slots[g], key);
    end

    assign hit = |match;
endmodule

// File: rtl/search_pipe_fifo.sv
module search_pipe_fifo
    import sfq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enq_valid,
    input  logic [1:0]       enq_kind,
    input  logic [REG_W-1:0] enq_dst,
    input  logic [VAL_W-1:0] enq_opa,
    input  logic [VAL_W-1:0] enq_opb,
    output logic             enq_rdy,
    input  logic             deq_en,
    output logic             deq_rdy,
    output logic [1:0]       head_kind,
    output logic [REG_W-1:0] head_dst,
    output logic [VAL_W-1:0] head_opa,
    output logic [VAL_W-1:0] head_opb,
    input  logic             clr,
    input  logic [REG_W-1:0] srch_reg,
    output logic             srch_hit
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tmpl_t         in_tmpl;
    tmpl_t         head_q;
    tmpl_t         slots [DEPTH];
    logic          enq_fire;
    logic          deq_fire;
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] occ;

    assign in_tmpl = '{kind: tmpl_kind_e'(enq_kind), dst: enq_dst,
                       opa: enq_opa, opb: enq_opb};

    sfq_ptr_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .enq_valid (enq_valid),
        .deq_en    (deq_en),
        .enq_rdy   (enq_rdy),
        .deq_rdy   (deq_rdy),
        .enq_fire  (enq_fire),
        .deq_fire  (deq_fire),
        .rd_ptr    (rd_ptr),
        .wr_ptr    (wr_ptr),
        .occ       (occ)
    );

    sfq_store #(.DEPTH(DEPTH), .PW(PW)) u_store (
        .clk     (clk),
        .wr_en   (enq_fire),
        .wr_ptr  (wr_ptr),
        .wr_data (in_tmpl),
        .rd_ptr  (rd_ptr),
        .head    (head_q),
        .slots   (slots)
    );

    // The lookup sees the state after a pop, so the head is skipped whenever
    // a pop is requested on a non-empty queue.
    sfq_search #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_search (
        .slots     (slots),
        .rd_ptr    (rd_ptr),
        .occ       (occ),
        .skip_head (deq_en && deq_rdy),
        .key       (srch_reg),
        .hit       (srch_hit)
    );

    assign head_kind = head_q.kind;
    assign head_dst  = head_q.dst;
    assign head_opa  = head_q.opa;
    assign head_opb  = head_q.opb;
endmodule

// File: rtl/sfq_checker.sv
module sfq_checker #(
    parameter int DEPTH = 4,
    parameter int CW    = 3,
    parameter int HW    = 71
) (
    input logic          clk,
    input logic          rst,
    input logic          clr,
    input logic          deq_en,
    input logic          deq_rdy,
    input logic          enq_rdy,
    input logic          srch_hit,
    input logic [HW-1:0] head_bits,
    input logic [CW-1:0] occ
);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        32'(occ) <= DEPTH);

    p_occ_unit_step_r3: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((occ == $past(occ)) || (occ == $past(occ) + 1'b1)
                  || (occ + 1'b1 == $past(occ))));

    p_full_swap_r4: assert property (@(posedge clk) disable iff (rst)
        (deq_en && deq_rdy) |-> enq_rdy);

    p_flush_empty_r5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!deq_rdy && enq_rdy && !srch_hit));

    p_head_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (deq_rdy && !deq_en && !clr) |=> (deq_rdy && $stable(head_bits)));

    p_empty_miss_r9: assert property (@(posedge clk) disable iff (rst)
        !deq_rdy |-> !srch_hit);
endmodule

bind search_pipe_fifo sfq_checker #(
    .DEPTH (DEPTH),
    .CW    (CW),
    .HW    (sfq_pkg::TMPL_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .deq_en    (deq_en),
    .deq_rdy   (deq_rdy),
    .enq_rdy   (enq_rdy),
    .srch_hit  (srch_hit),
    .head_bits (head_q),
    .occ       (occ)
);

// File: tb/sim_search_pipe_fifo.sv
`timescale 1ns/1ps
module sim_search_pipe_fifo;
    import sfq_pkg::*;

    localparam int D = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             enq_valid = 1'b0;
    logic [1:0]       enq_kind = '0;
    logic [REG_W-1:0] enq_dst = '0;
    logic [VAL_W-1:0] enq_opa = '0;
    logic [VAL_W-1:0] enq_opb = '0;
    logic             enq_rdy;
    logic             deq_en = 1'b0;
    logic             deq_rdy;
    logic [1:0]       head_kind;
    logic [REG_W-1:0] head_dst;
    logic [VAL_W-1:0] head_opa;
    logic [VAL_W-1:0] head_opb;
    logic             clr = 1'b0;
    logic [REG_W-1:0] srch_reg = '0;
    logic             srch_hit;

    int    n_chk  = 0;
    int    n_err  = 0;
    bit    done   = 1'b0;
    bit    was_clr = 1'b0;
    tmpl_t mdl [$];

    always #2 clk = ~clk;

    search_pipe_fifo #(.DEPTH(D)) u0 (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_kind(enq_kind), .enq_dst(enq_dst),
        .enq_opa(enq_opa), .enq_opb(enq_opb), .enq_rdy(enq_rdy),
        .deq_en(deq_en), .deq_rdy(deq_rdy),
        .head_kind(head_kind), .head_dst(head_dst),
        .head_opa(head_opa), .head_opb(head_opb),
        .clr(clr), .srch_reg(srch_reg), .srch_hit(srch_hit)
    );

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_hit(logic [REG_W-1:0] r, bit skip);
        for (int i = (skip ? 1 : 0); i < mdl.size(); i++) begin
            if ((mdl[i].kind == TK_ADD || mdl[i].kind == TK_LOAD) && mdl[i].dst == r)
                return 1'b1;
        end
        return 1'b0;
    endfunction

    task automatic step(bit ev, logic [1:0] k, logic [REG_W-1:0] dd,
                        bit de, bit cl, logic [REG_W-1:0] sr);
        int    n;
        bit    pop;
        bit    push;
        logic  eh;
        tmpl_t t;
        tmpl_t act_head;
        @(negedge clk);
        enq_valid = ev; enq_kind = k; enq_dst = dd;
        enq_opa = $urandom; enq_opb = $urandom;
        deq_en = de; clr = cl; srch_reg = sr;
        #1;
        n = mdl.size();
        chk(deq_rdy == (n > 0), was_clr ? "R5" : "R1", 128'(deq_rdy), 128'(n > 0));
        act_head = '{kind: tmpl_kind_e'(head_kind), dst: head_dst,
                     opa: head_opa, opb: head_opb};
        if (n > 0)
            chk(act_head == mdl[0], de ? "R6" : "R2", 128'(act_head), 128'(mdl[0]));
        chk(enq_rdy == ((n < D) || (de && n > 0)), (n == D) ? "R4" : "R3",
            128'(enq_rdy), 128'((n < D) || (de && n > 0)));
        eh = exp_hit(sr, de && n > 0);
        chk(srch_hit == eh, (n == 0) ? "R9" : ((de && n > 0) ? "R8" : "R7"),
            128'(srch_hit), 128'(eh));
        t = '{kind: tmpl_kind_e'(k), dst: dd, opa: enq_opa, opb: enq_opb};
        @(posedge clk);
        pop  = de && (n > 0) && !cl;
        push = ev && ((n < D) || (de && n > 0)) && !cl;
        if (cl) mdl.delete();
        if (pop) void'(mdl.pop_front());
        if (push) mdl.push_back(t);
        was_clr = cl;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10: empty after reset
        chk(deq_rdy == 1'b0, "R10", 128'(deq_rdy), 128'(0));
        chk(enq_rdy == 1'b1, "R10", 128'(enq_rdy), 128'(1));
        chk(srch_hit == 1'b0, "R10", 128'(srch_hit), 128'(0));

        // Directed: fill with one of each kind; R7 kinds branch/store never match
        step(1, 2'd0, 5'd3, 0, 0, 5'd3);
        step(1, 2'd2, 5'd5, 0, 0, 5'd3);
        step(1, 2'd1, 5'd7, 0, 0, 5'd5);
        step(1, 2'd3, 5'd9, 0, 0, 5'd7);
        // Full: push without pop is dropped (R3), branch/store keys miss (R7)
        step(1, 2'd0, 5'd11, 0, 0, 5'd9);
        step(0, 2'd0, 5'd0, 0, 0, 5'd11);
        // Full with pop and push together (R4); head dst 3 hidden (R8)
        step(1, 2'd0, 5'd12, 1, 0, 5'd3);
        step(0, 2'd0, 5'd0, 0, 0, 5'd12);
        // Same-cycle push is not visible to the lookup (R8)
        step(1, 2'd2, 5'd14, 1, 0, 5'd14);
        // Flush with push and pop requested (R5)
        step(1, 2'd0, 5'd20, 1, 1, 5'd5);
        step(0, 2'd0, 5'd0, 0, 0, 5'd20);
        // Pop on empty is ignored, lookup on empty misses (R9)
        step(0, 2'd0, 5'd0, 1, 0, 5'd0);
        // Depth-one turnover: push, then pop+push each cycle (R2, R6)
        for (int i = 0; i < 6; i++) step(1, 2'd0, 5'(i), i > 0, 0, 5'(i));

        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 100) < 60, 2'($urandom), 5'($urandom % 8),
                 ($urandom % 100) < 45, ($urandom % 100) < 3, 5'($urandom % 8));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule